// File: doc/BRIEF.md
# Virtual Address Region Guard and Translation Fault Recorder

This block sits in front of the translation lookaside buffer of a 32-bit processor. It sorts every memory access by address region and privilege mode. An access either passes through untranslated, goes through the TLB, or is refused as a privilege violation. For translated accesses it reads the hit flag, the physical frame number and the permission bits that an external TLB returns in the same cycle. It then produces the physical address or a fault cause. It also keeps the fault records that a trap handler reads: the faulting address, the page-number field of the page-table-entry address word, and a flag that separates data faults from instruction faults.

The region map is fixed. In supervisor mode the top quarter of the space (0xC0000000 and above) is identity-mapped, and everything below it is translated. In user mode the lower half is translated, and any access to the upper half faults. A configuration input turns the whole unit into a pass-through when no MMU is fitted. The response is registered and appears one cycle after the request and the TLB response.

Top module: `mmu_region_guard`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_fault, rsp_paddr, rsp_cause and all three fault records are zero.
- R2: With mmu_en low, every access is identity-mapped (rsp_paddr equals the virtual address) with no fault and no TLB request, whatever the mode, address or TLB inputs.
- R3: In supervisor mode with mmu_en high, an address at or above 0xC0000000 is identity-mapped with no fault and no TLB request.
- R4: Supervisor addresses below 0xC0000000 and user addresses below 0x80000000 raise tlb_req in the same cycle, with tlb_vpn equal to address bits [31:12]. On a hit with the needed permission, rsp_paddr is {tlb_pfn, address bits [11:0]} and there is no fault.
- R5: A user-mode access at or above 0x80000000 faults with cause 5 and raises no TLB request. rec_badaddr takes the address, and rec_pte_field and rec_data_flag keep their values.
- R6: A translated access that misses the TLB faults with cause 1.
- R7: The access kind encoding is 0 read, 1 write, 2 fetch, 3 treated as read. tlb_perm bit 0 grants read, bit 1 grants write and bit 2 grants execute. A hit without the needed bit faults with cause 2 (read), 3 (write) or 4 (fetch).
- R8: On a TLB miss or permission fault, rec_badaddr takes the address. rec_pte_field takes address bits [31:12] in its bits [21:2], with all other bits zero. rec_data_flag is cleared for a fetch and set for any other kind.
- R9: rsp_valid is high exactly one cycle after a cycle with req_valid high. In a cycle without a request, rsp_valid stays low and the fault records hold their values.
- R10: A faulted response carries rsp_paddr of zero and a nonzero cause. A response without a fault carries cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| mmu_en | input | 1 | MMU fitted; 0 makes every access identity-mapped |
| tlb_req | output | 1 | Lookup wanted for this access (combinational) |
| tlb_vpn | output | 20 | Virtual page number sent to the TLB |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_pfn | input | 20 | Physical frame number of the entry |
| tlb_perm | input | 3 | Entry permissions: bit0 read, bit1 write, bit2 execute |
| rsp_valid | output | 1 | Registered result valid |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 3 | 0 none, 1 miss, 2/3/4 read/write/execute denied, 5 privileged region |
| rec_badaddr | output | 32 | Address of the last faulting access |
| rec_pte_field | output | 32 | Page-number field of the page-table-entry address word, bits [21:2] |
| rec_data_flag | output | 1 | 1 if the last TLB fault was a data access, 0 if a fetch |

## Verification
The bench sweeps mode, MMU presence, all four address quarters, all four kind codes, hit and miss, and all eight permission patterns. A model in the bench predicts every response and record. The region edges matter most. A design that bypassed the 0x80000000–0xBFFFFFFF band for the supervisor would return untranslated addresses there. One that let users reach the upper half would return a TLB result instead of cause 5. The bench checks that a privileged-region fault leaves the page-number field and the data flag alone, and that a fetch clears the flag. A design that updated every record on every fault, or that inverted the flag, shows up in the record check that follows each access. Idle cycles are mixed in to catch records that drift or a valid that sticks.

// File: rtl/mmu_region_pkg.sv
package mmu_region_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_TLB_MISS  = 3'd1,
        CAUSE_DENY_RD   = 3'd2,
        CAUSE_DENY_WR   = 3'd3,
        CAUSE_DENY_EX   = 3'd4,
        CAUSE_PRIV_ADDR = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        ROUTE_IDENTITY  = 2'd0,
        ROUTE_TRANSLATE = 2'd1,
        ROUTE_PRIV_TRAP = 2'd2
    } route_e;

    typedef struct packed {
        logic   fault;
        logic   tlb_side;
        cause_e cause;
    } verdict_t;

    localparam int PERM_RD_BIT = 0;
    localparam int PERM_WR_BIT = 1;
    localparam int PERM_EX_BIT = 2;

    function automatic logic perm_granted(acc_kind_e kind, logic [2:0] perm);
        case (kind)
            ACC_WRITE: return perm[PERM_WR_BIT];
            ACC_FETCH: return perm[PERM_EX_BIT];
            default:   return perm[PERM_RD_BIT];
        endcase
    endfunction

    function automatic cause_e deny_cause(acc_kind_e kind);
        case (kind)
            ACC_WRITE: return CAUSE_DENY_WR;
            ACC_FETCH: return CAUSE_DENY_EX;
            default:   return CAUSE_DENY_RD;
        endcase
    endfunction

endpackage

// File: rtl/mmu_route_sel.sv
module mmu_route_sel
    import mmu_region_pkg::*;
(
    input  logic [1:0] top_bits,
    input  logic       is_super,
    input  logic       mmu_en,
    output route_e     route
);
    always_comb begin
        if (!mmu_en) begin
            route = ROUTE_IDENTITY;
        end else if (is_super) begin
            route = (top_bits == 2'b11) ? ROUTE_IDENTITY : ROUTE_TRANSLATE;
        end else begin
            route = top_bits[1] ? ROUTE_PRIV_TRAP : ROUTE_TRANSLATE;
        end
    end
endmodule

// File: rtl/mmu_perm_judge.sv
module mmu_perm_judge
    import mmu_region_pkg::*;
(
    input  route_e     route,
    input  acc_kind_e  kind,
    input  logic       hit,
    input  logic [2:0] perm,
    output verdict_t   verdict
);
    always_comb begin
        verdict = '{fault: 1'b0, tlb_side: 1'b0, cause: CAUSE_NONE};
        case (route)
            ROUTE_PRIV_TRAP: begin
                verdict.fault = 1'b1;
                verdict.cause = CAUSE_PRIV_ADDR;
            end
            ROUTE_TRANSLATE: begin
                if (!hit) begin
                    verdict.fault    = 1'b1;
                    verdict.tlb_side = 1'b1;
                    verdict.cause    = CAUSE_TLB_MISS;
                end else if (!perm_granted(kind, perm)) begin
                    verdict.fault    = 1'b1;
                    verdict.tlb_side = 1'b1;
                    verdict.cause    = deny_cause(kind);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mmu_fault_store.sv
module mmu_fault_store
    import mmu_region_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int PTE_LSB = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       vaddr,
    input  acc_kind_e             kind,
    input  route_e                route,
    input  verdict_t              verdict,
    input  logic [VA_W-PAGE_W-1:0] pfn,
    output logic                  rsp_valid,
    output logic [VA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output cause_e                rsp_cause,
    output logic [VA_W-1:0]       rec_badaddr,
    output logic [VA_W-1:0]       rec_pte_field,
    output logic                  rec_data_flag
);
    localparam int VPN_W = VA_W - PAGE_W;

    logic [VA_W-1:0] paddr_next;
    logic [VA_W-1:0] pte_next;

    always_comb begin
        if (verdict.fault) begin
            paddr_next = '0;
        end else if (route == ROUTE_TRANSLATE) begin
            paddr_next = {pfn, vaddr[PAGE_W-1:0]};
        end else begin
            paddr_next = vaddr;
        end
        pte_next = '0;
        pte_next[PTE_LSB +: VPN_W] = vaddr[VA_W-1:PAGE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_fault     <= 1'b0;
            rsp_cause     <= CAUSE_NONE;
            rec_badaddr   <= '0;
            rec_pte_field <= '0;
            rec_data_flag <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= paddr_next;
                rsp_fault <= verdict.fault;
                rsp_cause <= verdict.cause;
                if (verdict.fault) begin
                    rec_badaddr <= vaddr;
                end
                if (verdict.tlb_side) begin
                    rec_pte_field <= pte_next;
                    rec_data_flag <= (kind != ACC_FETCH);
                end
            end
        end
    end

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0 && rsp_cause != CAUSE_NONE)); // R10
    AST_CLEAN_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == CAUSE_NONE)); // R10
    AST_IDLE_RECORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rec_badaddr) && $stable(rec_pte_field) && $stable(rec_data_flag))); // R9
endmodule

// File: rtl/mmu_region_guard.sv
module mmu_region_guard
    import mmu_region_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int PTE_LSB = 2,
    localparam int VPN_W  = VA_W - PAGE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_super,
    input  logic             mmu_en,
    output logic             tlb_req,
    output logic [VPN_W-1:0] tlb_vpn,
    input  logic             tlb_hit,
    input  logic [VPN_W-1:0] tlb_pfn,
    input  logic [2:0]       tlb_perm,
    output logic             rsp_valid,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic [2:0]       rsp_cause,
    output logic [VA_W-1:0]  rec_badaddr,
    output logic [VA_W-1:0]  rec_pte_field,
    output logic             rec_data_flag
);
    route_e    route;
    verdict_t  verdict;
    acc_kind_e kind;
    cause_e    cause_q;

    assign kind = acc_kind_e'(req_kind);

    mmu_route_sel u_route (
        .top_bits (req_vaddr[VA_W-1:VA_W-2]),
        .is_super (req_super),
        .mmu_en   (mmu_en),
        .route    (route)
    );

    mmu_perm_judge u_judge (
        .route   (route),
        .kind    (kind),
        .hit     (tlb_hit),
        .perm    (tlb_perm),
        .verdict (verdict)
    );

    mmu_fault_store #(
        .VA_W    (VA_W),
        .PAGE_W  (PAGE_W),
        .PTE_LSB (PTE_LSB)
    ) u_store (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .vaddr         (req_vaddr),
        .kind          (kind),
        .route         (route),
        .verdict       (verdict),
        .pfn           (tlb_pfn),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .rsp_cause     (cause_q),
        .rec_badaddr   (rec_badaddr),
        .rec_pte_field (rec_pte_field),
        .rec_data_flag (rec_data_flag)
    );

    assign rsp_cause = cause_q;
    assign tlb_req   = req_valid && (route == ROUTE_TRANSLATE);
    assign tlb_vpn   = req_vaddr[VA_W-1:PAGE_W];

    AST_VALID_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R9
    AST_NOMMU_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mmu_en) |=> (!rsp_fault && rsp_paddr == $past(req_vaddr))); // R2
    AST_USER_UPPER_TRAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mmu_en && !req_super && req_vaddr[VA_W-1]) |=>
        (rsp_fault && rsp_cause == 3'd5 && rec_badaddr == $past(req_vaddr))); // R5
    AST_SUPER_TOP_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mmu_en && req_super && req_vaddr[VA_W-1:VA_W-2] == 2'b11) |=>
        (!rsp_fault && rsp_paddr == $past(req_vaddr))); // R3
    AST_TLB_REQ_REGION: assert property (@(posedge clk) disable iff (rst)
        tlb_req |-> (mmu_en && (req_super ? (req_vaddr[VA_W-1:VA_W-2] != 2'b11)
                                          : !req_vaddr[VA_W-1]))); // R4
    AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (tlb_req && !tlb_hit) |=> (rsp_fault && rsp_cause == 3'd1)); // R6
    AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !verdict.fault) |=> (rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0]))); // R4
endmodule

// File: tb/tb_mmu_region_guard.sv
module tb_mmu_region_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_super;
    logic        mmu_en;
    logic        tlb_req;
    logic [19:0] tlb_vpn;
    logic        tlb_hit;
    logic [19:0] tlb_pfn;
    logic [2:0]  tlb_perm;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;
    logic [31:0] rec_badaddr;
    logic [31:0] rec_pte_field;
    logic        rec_data_flag;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_bad;
    logic [31:0] m_pte;
    logic        m_dflag;

    always #2 clk = ~clk;

    mmu_region_guard dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_super(req_super), .mmu_en(mmu_en),
        .tlb_req(tlb_req), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit),
        .tlb_pfn(tlb_pfn), .tlb_perm(tlb_perm), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rec_badaddr(rec_badaddr), .rec_pte_field(rec_pte_field),
        .rec_data_flag(rec_data_flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_records(input string tag);
        check(tag, {rec_badaddr, rec_pte_field[30:0], rec_data_flag},
                   {m_bad, m_pte[30:0], m_dflag});
    endtask

    task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic sup,
                          input logic en, input logic hit, input logic [19:0] pfn,
                          input logic [2:0] perm);
        logic        exp_req;
        logic        fault;
        logic        tlbf;
        logic [2:0]  cause;
        logic [31:0] pa;
        int          bitn;
        exp_req = 1'b0; fault = 1'b0; tlbf = 1'b0; cause = 3'd0; pa = va;
        if (en) begin
            if (sup ? (va[31:30] != 2'b11) : !va[31]) begin
                exp_req = 1'b1;
                bitn = (kind == 2'd1) ? 1 : (kind == 2'd2) ? 2 : 0;
                if (!hit) begin
                    fault = 1'b1; tlbf = 1'b1; cause = 3'd1;
                end else if (!perm[bitn]) begin
                    fault = 1'b1; tlbf = 1'b1; cause = 3'(2 + bitn);
                end else begin
                    pa = {pfn, va[11:0]};
                end
            end else if (!sup) begin
                fault = 1'b1; cause = 3'd5;
            end
        end
        if (fault) pa = 32'd0;
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_super = sup;
        mmu_en = en; tlb_hit = hit; tlb_pfn = pfn; tlb_perm = perm;
        #1;
        check(en ? "R4 tlb_req/vpn" : "R2 no lookup", {tlb_req, exp_req ? tlb_vpn : 20'd0},
              {exp_req, exp_req ? va[31:12] : 20'd0});
        @(negedge clk);
        req_valid = 1'b0;
        if (fault) m_bad = va;
        if (tlbf) begin
            m_pte = {10'd0, va[31:12], 2'b00};
            m_dflag = (kind != 2'd2);
        end
        if (!en)                       check("R2 identity", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {2'b10, cause, pa});
        else if (cause == 3'd5)        check("R5 user upper", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {2'b11, cause, pa});
        else if (cause == 3'd1)        check("R6 miss", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {2'b11, cause, pa});
        else if (fault)                check("R7 perm deny", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {2'b11, cause, pa});
        else if (!exp_req)             check("R3 super bypass", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {2'b10, cause, pa});
        else                           check("R4 translate", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {2'b10, cause, pa});
        check_records(tlbf ? "R8 tlb records" : "R5 records");
        if (fault) check("R10 fault addr zero", {rsp_paddr, rsp_cause != 3'd0}, {32'd0, 1'b1});
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int iter;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_super = 1'b0;
        mmu_en = 1'b0; tlb_hit = 1'b0; tlb_pfn = '0; tlb_perm = '0;
        m_bad = '0; m_pte = '0; m_dflag = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", {rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, 64'd0);
        check_records("R1 reset records");
        rst = 1'b0;
        iter = 0;
        for (int sup = 0; sup < 2; sup++)
            for (int en = 0; en < 2; en++)
                for (int q = 0; q < 4; q++)
                    for (int k = 0; k < 4; k++)
                        for (int h = 0; h < 2; h++)
                            for (int p = 0; p < 8; p++) begin
                                logic [31:0] mix;
                                mix = 32'(iter) * 32'h0123_4567 ^ 32'h0000_02AB;
                                access({2'(q), mix[29:0]}, 2'(k), 1'(sup), 1'(en), 1'(h),
                                       20'(32'(iter) * 32'h9E37), 3'(p));
                                iter++;
                                if (iter % 7 == 0) begin
                                    @(negedge clk);
                                    check("R9 idle", {31'd0, rsp_valid}, 32'd0);
                                    check_records("R9 idle records hold");
                                end
                            end
        // region edges
        access(32'hBFFF_FFFF, 2'd0, 1'b1, 1'b1, 1'b1, 20'hABCDE, 3'b001);
        access(32'hC000_0000, 2'd2, 1'b1, 1'b1, 1'b0, 20'h00000, 3'b000);
        access(32'h7FFF_FFFF, 2'd2, 1'b0, 1'b1, 1'b0, 20'h00000, 3'b000);
        access(32'h8000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 20'h12345, 3'b111);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule